// File: doc/BRIEF.md
# IPv4 Fast-Path Header Rewriter

This block takes one complete 20-byte IPv4 header per transfer as a 160-bit word. Each header moves through three register stages. The first stage runs plausibility checks and folds the destination address into a route-cache index. The second stage lowers the time-to-live and patches the checksum. The third stage presents the result together with its index. A header that fails any check is marked for software handling and passes through bit-for-bit unchanged. A header that passes is rewritten and marked as fast.

The checksum that arrives with a header is never checked. The block only adjusts it to match the one-step TTL decrement, using one's-complement arithmetic. A header that arrived with a correct checksum therefore still has a correct one, and a damaged header is left for the end host to reject. Both edges use a valid/ready handshake. When the output stalls, the whole pipeline freezes. The path MTU is an input and is sampled at the moment a header is accepted.

The block has no state machine. Each stage holds a single occupancy bit that moves forward whenever the pipeline advances. The stages are named: check (stage 1), rewrite (stage 2) and emit (stage 3).

Top module: `ipv4_fastpath`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: With out_ready held high, a header accepted on one clock edge appears on the outputs after the third rising edge from acceptance. The block accepts one header per cycle.
- R3: While out_valid is 1 and out_ready is 0, out_valid, out_hdr, out_slow and out_tag hold their values and in_ready is 0.
- R4: A header whose version field (in_hdr[159:156]) is not 4, or whose header-length field (in_hdr[155:152]) is not 5, is marked slow (out_slow = 1).
- R5: A header whose total length (in_hdr[143:128]) is below 20 or above MAX_LEN is marked slow.
- R6: A header whose destination (in_hdr[31:0]) has top nibble 0xE (multicast) is marked slow.
- R7: A header whose total length exceeds the mtu value sampled at acceptance is marked slow. A length equal to mtu is not.
- R8: A header whose TTL (in_hdr[95:88]) is 0 or 1 is marked slow.
- R9: For a fast header, out_hdr equals the input with TTL reduced by one and the checksum (bits 79:64) replaced by the one's-complement sum of the old checksum and 0x0100, with the carry wrapped around. The incoming checksum is not checked, so a valid header stays valid.
- R10: A slow header leaves with out_hdr identical to the accepted in_hdr.
- R11: Bit k of out_tag is the XOR of all destination bits i with i mod HASH_W equal to k. This holds for fast and slow headers alike.
- R12: Headers leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mtu | input | 16 | Path MTU in bytes, sampled on acceptance |
| in_valid | input | 1 | Header offered |
| in_ready | output | 1 | Block can take a header this cycle |
| in_hdr | input | 160 | Header, first byte in bits 159:152 |
| out_valid | output | 1 | Processed header present |
| out_ready | input | 1 | Consumer takes the header this cycle |
| out_hdr | output | 160 | Rewritten or unchanged header |
| out_slow | output | 1 | 1 = needs slow-path handling |
| out_tag | output | HASH_W | Route-cache index from the destination |

## Verification
The embedded properties assume only that reset is held for at least one edge. They make no assumption about header contents or mtu: every fast-path property is an invariant of what may legally leave the block, whatever is offered. The same holds for the stall property, which depends on out_ready alone.

The stimulus keeps in_valid and in_hdr steady until the header is accepted, and changes mtu only together with a new header. This matches the sampling rule in R7. Most headers carry a correct checksum, so the rewritten checksum can be tested against a full recomputation. A few carry a deliberately wrong one, to show that the block does not check it.

// File: rtl/ipv4_fp_pkg.sv
package ipv4_fp_pkg;
    localparam int HDR_W   = 160;
    localparam int VER_LSB = 156;
    localparam int IHL_LSB = 152;
    localparam int LEN_LSB = 128;
    localparam int TTL_LSB = 88;
    localparam int CK_LSB  = 64;

    // one's-complement 16-bit add with end-around carry
    function automatic logic [15:0] oc_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[15:0] + {15'd0, s[16]};
    endfunction
endpackage

// File: rtl/ipv4_fp_check.sv
module ipv4_fp_check #(
    parameter int          HASH_W  = 8,
    parameter logic [15:0] MAX_LEN = 16'd9216
) (
    input  logic [7:0]        ver_ihl,
    input  logic [15:0]       tot_len,
    input  logic [7:0]        ttl,
    input  logic [31:0]       dst,
    input  logic [15:0]       mtu,
    output logic              slow,
    output logic [HASH_W-1:0] tag
);
    logic bad_form, bad_len, mcast, frag, dying;

    always_comb begin
        bad_form = (ver_ihl != 8'h45);
        bad_len  = (tot_len < 16'd20) || (tot_len > MAX_LEN);
        mcast    = (dst[31:28] == 4'hE);
        frag     = (tot_len > mtu);
        dying    = (ttl <= 8'd1);
        slow     = bad_form | bad_len | mcast | frag | dying;
    end

    always_comb begin
        tag = '0;
        for (int i = 0; i < 32; i++) begin
            tag[i % HASH_W] = tag[i % HASH_W] ^ dst[i];
        end
    end
endmodule

// File: rtl/ipv4_fp_rewrite.sv
module ipv4_fp_rewrite
    import ipv4_fp_pkg::*;
(
    input  logic [HDR_W-1:0] hdr_in,
    input  logic             slow,
    output logic [HDR_W-1:0] hdr_out
);
    always_comb begin
        hdr_out = hdr_in;
        if (!slow) begin
            hdr_out[TTL_LSB +: 8] = hdr_in[TTL_LSB +: 8] - 8'd1;
            hdr_out[CK_LSB +: 16] = oc_add(hdr_in[CK_LSB +: 16], 16'h0100);
        end
    end
endmodule

// File: rtl/ipv4_fp_preg.sv
module ipv4_fp_preg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             d_valid,
    input  logic [WIDTH-1:0] d,
    output logic             q_valid,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else if (en) begin
            q_valid <= d_valid;
            q       <= d;
        end
    end
endmodule

// File: rtl/ipv4_fastpath.sv
module ipv4_fastpath
    import ipv4_fp_pkg::*;
#(
    parameter int          HASH_W  = 8,
    parameter logic [15:0] MAX_LEN = 16'd9216
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       mtu,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [159:0]      in_hdr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [159:0]      out_hdr,
    output logic              out_slow,
    output logic [HASH_W-1:0] out_tag
);
    localparam int NSTG = 3;
    localparam int BUS_W = HDR_W + 1 + HASH_W;

    logic [BUS_W-1:0] stg_d [NSTG];
    logic [BUS_W-1:0] stg_q [NSTG];
    logic             stg_dv[NSTG];
    logic             stg_qv[NSTG];
    logic             advance;

    logic              chk_slow;
    logic [HASH_W-1:0] chk_tag;
    logic [HDR_W-1:0]  rw_hdr;

    assign advance  = !stg_qv[NSTG-1] || out_ready;
    assign in_ready = advance;

    // check stage
    ipv4_fp_check #(.HASH_W(HASH_W), .MAX_LEN(MAX_LEN)) u_check (
        .ver_ihl (in_hdr[IHL_LSB +: 8]),
        .tot_len (in_hdr[LEN_LSB +: 16]),
        .ttl     (in_hdr[TTL_LSB +: 8]),
        .dst     (in_hdr[31:0]),
        .mtu     (mtu),
        .slow    (chk_slow),
        .tag     (chk_tag)
    );

    // rewrite stage
    ipv4_fp_rewrite u_rewrite (
        .hdr_in  (stg_q[0][BUS_W-1 -: HDR_W]),
        .slow    (stg_q[0][HASH_W]),
        .hdr_out (rw_hdr)
    );

    assign stg_d[0]  = {in_hdr, chk_slow, chk_tag};
    assign stg_dv[0] = in_valid;
    assign stg_d[1]  = {rw_hdr, stg_q[0][HASH_W:0]};
    assign stg_dv[1] = stg_qv[0];
    assign stg_d[2]  = stg_q[1];
    assign stg_dv[2] = stg_qv[1];

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        ipv4_fp_preg #(.WIDTH(BUS_W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (advance),
            .d_valid (stg_dv[g]),
            .d       (stg_d[g]),
            .q_valid (stg_qv[g]),
            .q       (stg_q[g])
        );
    end

    // emit stage
    assign out_valid = stg_qv[NSTG-1];
    assign out_hdr   = stg_q[NSTG-1][BUS_W-1 -: HDR_W];
    assign out_slow  = stg_q[NSTG-1][HASH_W];
    assign out_tag   = stg_q[NSTG-1][HASH_W-1:0];

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_hdr) && $stable(out_slow) && $stable(out_tag));
    // R4
    fast_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_slow |-> out_hdr[IHL_LSB +: 8] == 8'h45);
    // R5
    fast_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_slow |-> out_hdr[LEN_LSB +: 16] >= 16'd20 && out_hdr[LEN_LSB +: 16] <= MAX_LEN);
    // R6
    fast_ucast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_slow |-> out_hdr[31:28] != 4'hE);
    // R8
    fast_ttl_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_slow |-> out_hdr[TTL_LSB +: 8] != 8'd0);
endmodule

// File: tb/ipv4_fastpath_bench.sv
module ipv4_fastpath_bench;
    localparam int          HW   = 8;
    localparam logic [15:0] MAXL = 16'd9216;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] mtu = 16'd1500;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [159:0] in_hdr = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [159:0] out_hdr;
    logic out_slow;
    logic [HW-1:0] out_tag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit strict_lat = 1'b1;
    bit bp_on = 1'b0;

    logic [159:0] q_hdr[$];
    bit           q_slow[$];
    logic [HW-1:0] q_tag[$];
    int           q_cyc[$];
    bit           q_full[$];
    string        q_why[$];

    bit           stall_prev = 1'b0;
    logic [159:0] stall_hdr;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ipv4_fastpath #(.HASH_W(HW), .MAX_LEN(MAXL)) u_ipv4_fastpath (
        .clk(clk), .rst_n(rst_n), .mtu(mtu), .in_valid(in_valid), .in_ready(in_ready),
        .in_hdr(in_hdr), .out_valid(out_valid), .out_ready(out_ready),
        .out_hdr(out_hdr), .out_slow(out_slow), .out_tag(out_tag)
    );

    function automatic logic [15:0] ocsum(input logic [159:0] h);
        int s = 0;
        for (int i = 0; i < 10; i++) s += int'(h[i*16 +: 16]);
        while (s > 32'hFFFF) s = (s & 32'hFFFF) + (s >> 16);
        return s[15:0];
    endfunction

    function automatic logic [159:0] mk(input logic [7:0] vi, input logic [15:0] len,
                                        input logic [15:0] id, input logic [7:0] ttl,
                                        input logic [31:0] dst, input bit good);
        logic [159:0] h;
        h = {vi, 8'h00, len, id, 16'h4000, ttl, 8'd17, 16'h0000, 32'h0A01_0203, dst};
        h[79:64] = ~ocsum(h);
        if (!good) h[79:64] = h[79:64] ^ 16'h1234;
        return h;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: sample mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev) begin
                chk(out_valid && out_hdr == stall_hdr, "R3 hold", out_hdr, stall_hdr);
            end
            stall_prev = out_valid && !out_ready;
            stall_hdr  = out_hdr;
            if (stall_prev) chk(!in_ready, "R3 in_ready", {159'd0, in_ready}, 160'd0);

            if (in_valid && in_ready) begin
                logic [159:0] e;
                logic [HW-1:0] t;
                logic [16:0] s;
                bit sl;
                string why;
                e = in_hdr; t = '0; sl = 1'b1; why = "R9";
                for (int i = 0; i < 32; i++) t[i % HW] ^= in_hdr[i];
                if (in_hdr[159:152] != 8'h45) why = "R4";
                else if (in_hdr[143:128] < 20 || in_hdr[143:128] > MAXL) why = "R5";
                else if (in_hdr[31:28] == 4'hE) why = "R6";
                else if (in_hdr[143:128] > mtu) why = "R7";
                else if (in_hdr[95:88] <= 1) why = "R8";
                else sl = 1'b0;
                if (!sl) begin
                    e[95:88] = in_hdr[95:88] - 8'd1;
                    s = {1'b0, in_hdr[79:64]} + 17'h0100;
                    e[79:64] = s[15:0] + {15'd0, s[16]};
                end else if (why != "R9") begin
                    why = {why, "/R10"};
                end
                q_hdr.push_back(e); q_slow.push_back(sl); q_tag.push_back(t);
                q_cyc.push_back(cyc); q_why.push_back(why);
                q_full.push_back(!sl && ocsum(in_hdr) == 16'hFFFF);
            end

            if (out_valid && out_ready) begin
                if (q_hdr.size() == 0) begin
                    chk(1'b0, "R12 unexpected output", out_hdr, 160'd0);
                end else begin
                    logic [159:0] e;
                    string why;
                    int c;
                    bit f;
                    e = q_hdr.pop_front(); why = q_why.pop_front();
                    c = q_cyc.pop_front(); f = q_full.pop_front();
                    chk(out_slow == q_slow.pop_front(), {why, " slow flag"}, {159'd0, out_slow}, 160'd0);
                    chk(out_hdr[127:112] == e[127:112], "R12 order", out_hdr, e);
                    chk(out_hdr == e, {why, " header"}, out_hdr, e);
                    chk(out_tag == q_tag.pop_front(), "R11 tag", {152'd0, out_tag}, 160'd0);
                    if (f) chk(ocsum(out_hdr) == 16'hFFFF, "R9 full recompute", {144'd0, ocsum(out_hdr)}, 160'hFFFF);
                    if (strict_lat) chk(cyc - c == 3, "R2 latency", 160'(cyc - c), 160'd3);
                end
            end

            if (cyc > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog actual %0d expected below 150000", cyc);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    // consumer backpressure
    always @(posedge clk) begin
        #1;
        out_ready <= bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    task automatic send(input logic [159:0] h, input logic [15:0] m);
        @(posedge clk); #1;
        in_valid = 1'b1; in_hdr = h; mtu = m;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (q_hdr.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [15:0] id;
        id = 16'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!out_valid && in_ready, "R1 reset state", {158'd0, out_valid, in_ready}, 160'd1);

        // directed corners
        send(mk(8'h65, 16'd100, id++, 8'd64, 32'h0A000001, 1), 16'd1500); // R4 version
        send(mk(8'h46, 16'd100, id++, 8'd64, 32'h0A000001, 1), 16'd1500); // R4 options
        send(mk(8'h45, 16'd19,  id++, 8'd64, 32'h0A000001, 1), 16'd1500); // R5 short
        send(mk(8'h45, 16'd20,  id++, 8'd64, 32'h0A000001, 1), 16'd1500); // R5 min ok
        send(mk(8'h45, MAXL,    id++, 8'd64, 32'h0A000001, 1), 16'hFFFF); // R5 max ok
        send(mk(8'h45, MAXL + 16'd1, id++, 8'd64, 32'h0A000001, 1), 16'hFFFF); // R5 long
        send(mk(8'h45, 16'd1500, id++, 8'd64, 32'hC0A80001, 1), 16'd1500); // R7 equal
        send(mk(8'h45, 16'd1501, id++, 8'd64, 32'hC0A80001, 1), 16'd1500); // R7 over
        send(mk(8'h45, 16'd60, id++, 8'd0, 32'h0A000001, 1), 16'd1500);   // R8
        send(mk(8'h45, 16'd60, id++, 8'd1, 32'h0A000001, 1), 16'd1500);   // R8
        send(mk(8'h45, 16'd60, id++, 8'd2, 32'h0A000001, 1), 16'd1500);   // R8 edge fast
        send(mk(8'h45, 16'd60, id++, 8'd64, 32'hE0000001, 1), 16'd1500); // R6
        send(mk(8'h45, 16'd60, id++, 8'd64, 32'hEFFFFFFF, 1), 16'd1500); // R6
        send(mk(8'h45, 16'd60, id++, 8'd64, 32'hDFFFFFFF, 1), 16'd1500); // R6 edge fast
        send(mk(8'h45, 16'd60, id++, 8'd64, 32'hF0000000, 1), 16'd1500); // R6 edge fast
        send(mk(8'h45, 16'd60, id++, 8'd64, 32'h0A000001, 0), 16'd1500); // R9 bad sum kept fast
        send(mk(8'h45, 16'd60, id++, 8'd255, 32'hFFFFFFFE, 1), 16'd1500); // R11 pattern
        drain();

        // back-to-back random stream, no backpressure
        fork
            begin
                for (int n = 0; n < 300; n++) begin
                    send(mk(($urandom_range(0, 15) == 0) ? 8'h47 : 8'h45,
                            16'($urandom_range(16, 1700)), id++, 8'($urandom_range(0, 255)),
                            $urandom(), $urandom_range(0, 9) != 0),
                         16'($urandom_range(576, 1600)));
                end
            end
        join
        drain();

        // random stream with backpressure and gaps
        strict_lat = 1'b0;
        bp_on = 1'b1;
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 3) == 0) @(posedge clk);
            send(mk(8'h45, 16'($urandom_range(16, 1700)), id++, 8'($urandom_range(0, 255)),
                    $urandom(), 1), 16'($urandom_range(576, 1600)));
        end
        bp_on = 1'b0;
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule